// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits on the receive side of an Ethernet MAC, directly after the start-of-frame delimiter has been stripped. It watches the octet stream of each arriving frame. It collects the first six octets, which form the destination address, and issues a single accept-or-reject verdict for the frame. The rest of the receive path uses that verdict to decide whether the frame is stored. Frame check sequence validation and buffering are not part of this block.

Each address falls into one of three classes. An address of all ones is broadcast. Any other address whose first octet has bit 0 set is multicast. Every remaining address is unicast. Unicast addresses are compared with the station's own 48-bit address. Multicast addresses are reduced to a six-bit hash and looked up in a 64-bit table. A two-bit policy input decides which classes may pass. The station address, the hash table and the policy are static inputs, and the block samples them on the cycle the sixth octet arrives.

The hash is the upper six bits of a CRC-32 computed over the six address octets. The CRC uses the generator 0x04C11DB7, starts from all ones, and takes each octet least significant bit first. The hash value h selects table bit h. Seen as eight byte-wide table registers, that is register h[5:3], bit h[2:0].

Top module: `daf_top`

## Requirements
- R1: While reset is held, and on the first sampled cycle after it, `dec_valid` and `dec_accept` are 0.
- R2: `dec_valid` pulses high for exactly one cycle, on the cycle after the clock edge that samples the sixth address octet. Each frame gets exactly one verdict. Octets after the sixth, up to the next `rx_sof`, produce no further verdict.
- R3: Unicast (first octet bit 0 = 0, not all ones) reports `dec_class` = 0. Under policies 1 and 2 it is accepted only when all six octets equal `node_addr`. The first octet on the wire corresponds to `node_addr[7:0]`, and octet k to `node_addr[8k+7:8k]`.
- R4: The all-ones address reports `dec_class` = 1 and is accepted under policies 1, 2 and 3.
- R5: Any other address with first-octet bit 0 = 1 reports `dec_class` = 2. Under policy 2 it is accepted exactly when `hash_tbl[h]` is 1. Here h is bits 31:26 of a CRC-32 with generator 0x04C11DB7, preset all ones, fed the six octets in wire order, each LSB first.
- R6: Policy 0 rejects every frame.
- R7: Policy 1 rejects every multicast frame, whatever the hash table holds.
- R8: Policy 3 accepts every frame.
- R9: Cycles with `rx_valid` low do not advance address capture. An `rx_sof` octet always restarts capture as octet 0, even in the middle of an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Octet on `rx_octet` is valid this cycle |
| rx_sof | input | 1 | Marks the first octet after the start-of-frame delimiter |
| rx_octet | input | 8 | Received octet |
| node_addr | input | 48 | Station address, octet k at bits 8k+7:8k |
| hash_tbl | input | 64 | Multicast hash table, bit h admits hash h |
| filt_mode | input | 2 | Policy: 0 none, 1 station+broadcast, 2 station+broadcast+hashed multicast, 3 all |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Frame accepted (meaningful with `dec_valid`) |
| dec_class | output | 2 | 0 unicast, 1 broadcast, 2 multicast |

## Verification
On every cycle, the assertions check the following:
- The verdict strobe lines up with the final address octet and never lasts two cycles.
- Policies 0 and 3 force the verdict.
- Broadcast always passes under the permissive policies.
- Multicast never passes under policy 1.
- Unicast and hashed-multicast verdicts agree with the station-match and table-lookup results from the classifier.

Only the bench's scenarios can show that those results are themselves correct, because the bench computes the CRC independently. The scenarios cover:
- octet ordering against the station address;
- the hash index landing on the right table bit;
- restart on a mid-address start marker;
- idle gaps;
- payload octets that must not raise another verdict.

// File: rtl/daf_pkg.sv
package daf_pkg;

  localparam int unsigned OCTET_W = 8;
  localparam int unsigned CRC_W   = 32;

  typedef enum logic [1:0] {
    CLS_UNICAST   = 2'd0,
    CLS_BROADCAST = 2'd1,
    CLS_MULTICAST = 2'd2
  } addr_class_e;

  typedef enum logic [1:0] {
    POL_DROP_ALL     = 2'd0,
    POL_STATION      = 2'd1,
    POL_STATION_HASH = 2'd2,
    POL_ALL          = 2'd3
  } filt_policy_e;

  // Advance a left-shifting CRC register by one octet, octet LSB first.
  function automatic logic [CRC_W-1:0] crc_octet(
    input logic [CRC_W-1:0]   crc_in,
    input logic [OCTET_W-1:0] octet,
    input logic [CRC_W-1:0]   poly
  );
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_in;
    for (int i = 0; i < OCTET_W; i++) begin
      fb = c[CRC_W-1] ^ octet[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/daf_capture.sv
module daf_capture
  import daf_pkg::*;
#(
  parameter int unsigned      ADDR_BYTES = 6,
  parameter int unsigned      HASH_BITS  = 6,
  parameter logic [CRC_W-1:0] CRC_POLY   = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] CRC_PRESET = 32'hFFFF_FFFF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_sof,
  input  logic [OCTET_W-1:0]            in_octet,
  output logic [ADDR_BYTES*OCTET_W-1:0] addr_full,
  output logic [HASH_BITS-1:0]          hash_code,
  output logic                          last_octet
);

  localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W;
  localparam int unsigned IDX_W  = $clog2(ADDR_BYTES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CRC_W-1:0]  crc_q;

  logic              take;
  logic [IDX_W-1:0]  cur_idx;
  logic [CRC_W-1:0]  crc_base;
  logic [CRC_W-1:0]  crc_next;
  logic [ADDR_W-1:0] addr_next;

  assign take     = in_valid && (in_sof || active_q);
  assign cur_idx  = in_sof ? '0 : idx_q;
  assign crc_base = in_sof ? CRC_PRESET : crc_q;
  assign crc_next = crc_octet(crc_base, in_octet, CRC_POLY);

  // One lane per address octet: load on its index, clear on a fresh start.
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
    always_comb begin
      if (take && (cur_idx == IDX_W'(k)))
        addr_next[k*OCTET_W +: OCTET_W] = in_octet;
      else if (in_sof)
        addr_next[k*OCTET_W +: OCTET_W] = '0;
      else
        addr_next[k*OCTET_W +: OCTET_W] = addr_q[k*OCTET_W +: OCTET_W];
    end
  end

  assign last_octet = take && (cur_idx == LAST_IDX);
  assign addr_full  = addr_next;
  assign hash_code  = crc_next[CRC_W-1 -: HASH_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      addr_q   <= '0;
      crc_q    <= CRC_PRESET;
    end else if (take) begin
      active_q <= !last_octet;
      idx_q    <= cur_idx + IDX_W'(1);
      addr_q   <= addr_next;
      crc_q    <= crc_next;
    end
  end

endmodule

// File: rtl/daf_classify.sv
module daf_classify
  import daf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_BITS  = 6
) (
  input  logic [ADDR_BYTES*OCTET_W-1:0] addr,
  input  logic [HASH_BITS-1:0]          hash_code,
  input  logic [ADDR_BYTES*OCTET_W-1:0] node_addr,
  input  logic [(1<<HASH_BITS)-1:0]     hash_tbl,
  output addr_class_e                   cls,
  output logic                          station_hit,
  output logic                          hash_hit
);

  logic [ADDR_BYTES-1:0] octet_eq;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_cmp
    assign octet_eq[k] = (addr[k*OCTET_W +: OCTET_W] == node_addr[k*OCTET_W +: OCTET_W]);
  end

  assign station_hit = &octet_eq;
  assign hash_hit    = hash_tbl[hash_code];

  always_comb begin
    if (&addr)        cls = CLS_BROADCAST;
    else if (addr[0]) cls = CLS_MULTICAST;
    else              cls = CLS_UNICAST;
  end

endmodule

// File: rtl/daf_policy.sv
module daf_policy
  import daf_pkg::*;
(
  input  logic [1:0]  mode,
  input  addr_class_e cls,
  input  logic        station_hit,
  input  logic        hash_hit,
  output logic        accept
);

  filt_policy_e pol;
  logic         open_path;

  assign pol = filt_policy_e'(mode);

  // Path shared by both selective policies.
  assign open_path = (cls == CLS_BROADCAST) || ((cls == CLS_UNICAST) && station_hit);

  always_comb begin
    unique case (pol)
      POL_DROP_ALL:     accept = 1'b0;
      POL_STATION:      accept = open_path;
      POL_STATION_HASH: accept = open_path || ((cls == CLS_MULTICAST) && hash_hit);
      POL_ALL:          accept = 1'b1;
      default:          accept = 1'b0;
    endcase
  end

endmodule

// File: rtl/daf_top.sv
module daf_top
  import daf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_BITS  = 6,
  localparam int unsigned ADDR_W    = ADDR_BYTES * OCTET_W,
  localparam int unsigned TBL_W     = 1 << HASH_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_octet,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic [TBL_W-1:0]  hash_tbl,
  input  logic [1:0]        filt_mode,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [1:0]        dec_class
);

  logic [ADDR_W-1:0]    w_addr;
  logic [HASH_BITS-1:0] w_hash_code;
  logic                 w_last_octet;
  addr_class_e          w_cls;
  logic                 w_station_hit;
  logic                 w_hash_hit;
  logic                 w_accept;

  daf_capture #(
    .ADDR_BYTES (ADDR_BYTES),
    .HASH_BITS  (HASH_BITS)
  ) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rx_valid),
    .in_sof     (rx_sof),
    .in_octet   (rx_octet),
    .addr_full  (w_addr),
    .hash_code  (w_hash_code),
    .last_octet (w_last_octet)
  );

  daf_classify #(
    .ADDR_BYTES (ADDR_BYTES),
    .HASH_BITS  (HASH_BITS)
  ) u_classify (
    .addr        (w_addr),
    .hash_code   (w_hash_code),
    .node_addr   (node_addr),
    .hash_tbl    (hash_tbl),
    .cls         (w_cls),
    .station_hit (w_station_hit),
    .hash_hit    (w_hash_hit)
  );

  daf_policy u_policy (
    .mode        (filt_mode),
    .cls         (w_cls),
    .station_hit (w_station_hit),
    .hash_hit    (w_hash_hit),
    .accept      (w_accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_class  <= CLS_UNICAST;
    end else begin
      dec_valid  <= w_last_octet;
      dec_accept <= w_last_octet && w_accept;
      if (w_last_octet) dec_class <= w_cls;
    end
  end

endmodule

// File: rtl/daf_checker.sv
module daf_checker
  import daf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [1:0] filt_mode,
  input logic       dec_valid,
  input logic       dec_accept,
  input logic [1:0] dec_class,
  input logic       last_octet,
  input logic       station_hit,
  input logic       hash_hit
);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R2

  AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_octet |=> dec_valid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(last_octet)); // R2

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_octet |-> rx_valid); // R9

  AST_DROP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(filt_mode) == 2'd0) |-> !dec_accept); // R6

  AST_PROMISC: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(filt_mode) == 2'd3) |-> dec_accept); // R8

  AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == CLS_BROADCAST && $past(filt_mode) != 2'd0) |-> dec_accept); // R4

  AST_MCAST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == CLS_MULTICAST && $past(filt_mode) == 2'd1) |-> !dec_accept); // R7

  AST_UNICAST_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == CLS_UNICAST && $past(filt_mode) inside {2'd1, 2'd2}
     && !$past(station_hit)) |-> !dec_accept); // R3

  AST_HASH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == CLS_MULTICAST && $past(filt_mode) == 2'd2)
    |-> (dec_accept == $past(hash_hit))); // R5

endmodule

bind daf_top daf_checker u_daf_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .filt_mode   (filt_mode),
  .dec_valid   (dec_valid),
  .dec_accept  (dec_accept),
  .dec_class   (dec_class),
  .last_octet  (w_last_octet),
  .station_hit (w_station_hit),
  .hash_hit    (w_hash_hit)
);

// File: tb/test_daf_top.sv
module test_daf_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid;
  logic        rx_sof;
  logic [7:0]  rx_octet;
  logic [47:0] node_addr;
  logic [63:0] hash_tbl;
  logic [1:0]  filt_mode;
  logic        dec_valid;
  logic        dec_accept;
  logic [1:0]  dec_class;

  int checks = 0;
  int errors = 0;
  int verdicts = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  daf_top i_daf_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_sof     (rx_sof),
    .rx_octet   (rx_octet),
    .node_addr  (node_addr),
    .hash_tbl   (hash_tbl),
    .filt_mode  (filt_mode),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_class  (dec_class)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reflected-register form of the same CRC: shift right with the mirrored generator.
  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [31:0] r;
    logic        fb;
    r = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      fb = r[0] ^ a[n];
      r  = r >> 1;
      if (fb) r = r ^ 32'hEDB8_8320;
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  function automatic logic [2:0] ref_verdict(input logic [47:0] a, input logic [1:0] m,
                                            input logic [47:0] node, input logic [63:0] tbl);
    logic [1:0] c;
    logic       acc;
    if (a == '1)     c = 2'd1;
    else if (a[0])   c = 2'd2;
    else             c = 2'd0;
    case (m)
      2'd0: acc = 1'b0;
      2'd3: acc = 1'b1;
      default: begin
        acc = (c == 2'd1) || (c == 2'd0 && a == node);
        if (m == 2'd2 && c == 2'd2) acc = tbl[ref_hash(a)];
      end
    endcase
    return {acc, c};
  endfunction

  task automatic drive_octet(input logic [7:0] v, input bit sof);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_sof   = sof;
    rx_octet = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b0;
      rx_sof   = 1'b0;
      rx_octet = 8'h00;
    end
  endtask

  task automatic send_frame(input logic [47:0] a, input int gap, input int tail,
                            input bit end_idle, input string tag);
    exp_q.push_back(ref_verdict(a, filt_mode, node_addr, hash_tbl));
    tag_q.push_back(tag);
    for (int k = 0; k < 6; k++) begin
      drive_octet(a[8*k +: 8], k == 0);
      if (gap > 0 && k < 5) idle(gap);
    end
    for (int t = 0; t < tail; t++) drive_octet(8'(t * 37 + 5), 1'b0);
    if (end_idle) idle(2);
  endtask

  task automatic send_partial(input logic [47:0] a, input int n);
    for (int k = 0; k < n; k++) drive_octet(a[8*k +: 8], k == 0);
  endtask

  // Monitor: every verdict must match the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && dec_valid === 1'b1) begin
      verdicts++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 spurious verdict", 1, 0);
      end else begin
        logic [2:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dec_class == e[1:0], {t, " class"}, int'(dec_class), int'(e[1:0]));
        check(dec_accept == e[2], {t, " accept"}, int'(dec_accept), int'(e[2]));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] node;
    logic [47:0] mc;
    logic [5:0]  h;
    node      = 48'h5634_1200_AB02;
    rst_n     = 1'b0;
    rx_valid  = 1'b0;
    rx_sof    = 1'b0;
    rx_octet  = 8'h00;
    node_addr = node;
    hash_tbl  = '0;
    filt_mode = 2'd1;
    repeat (3) @(negedge clk);
    check(dec_valid == 1'b0, "R1 valid in reset", int'(dec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dec_valid == 1'b0, "R1 valid after reset", int'(dec_valid), 0);
    check(dec_accept == 1'b0, "R1 accept after reset", int'(dec_accept), 0);

    // R3 station address, octet ordering
    send_frame(node, 0, 0, 1, "R3 own address");
    send_frame(node ^ 48'h0100_0000_0000, 0, 0, 1, "R3 last octet differs");
    send_frame(node ^ 48'h0000_0000_0080, 0, 0, 1, "R3 first octet differs");
    send_frame({node[7:0], node[47:8]}, 0, 0, 1, "R3 rotated octets");

    // R4 broadcast under each permissive policy
    send_frame('1, 0, 0, 1, "R4 broadcast p1");
    filt_mode = 2'd2;
    send_frame('1, 0, 0, 1, "R4 broadcast p2");
    send_frame(node, 0, 0, 1, "R3 own address p2");
    filt_mode = 2'd3;
    send_frame('1, 0, 0, 1, "R4 broadcast p3");

    // R7 multicast blocked under policy 1 even with a full table
    filt_mode = 2'd1;
    hash_tbl  = '1;
    send_frame(48'h0300_005E_0001, 0, 0, 1, "R7 multicast p1");

    // R5 hashed multicast: only the selected bit matters
    filt_mode = 2'd2;
    for (int j = 0; j < 8; j++) begin
      mc = {8'(j * 29 + 3), 8'(j * 11), 8'h5E, 8'h00, 8'h10 + 8'(j), 8'h01};
      h  = ref_hash(mc);
      hash_tbl = 64'd1 << h;
      send_frame(mc, 0, 0, 1, "R5 hash bit set");
      hash_tbl = ~(64'd1 << h);
      send_frame(mc, 0, 0, 1, "R5 hash bit clear");
    end

    // R6 drop all
    filt_mode = 2'd0;
    hash_tbl  = '1;
    send_frame(node, 0, 0, 1, "R6 own address");
    send_frame('1, 0, 0, 1, "R6 broadcast");
    send_frame(48'h0300_005E_0001, 0, 0, 1, "R6 multicast");

    // R8 promiscuous
    filt_mode = 2'd3;
    hash_tbl  = '0;
    send_frame(48'h0A0B_0C0D_0E10, 0, 0, 1, "R8 foreign unicast");
    send_frame(48'h0300_005E_0001, 0, 0, 1, "R8 multicast empty table");

    // R9 gaps and restart; R2 payload and back-to-back
    filt_mode = 2'd1;
    send_frame(node, 3, 0, 1, "R9 gaps between octets");
    send_partial(48'hFFFF_FFFF_FFFF, 3);
    send_frame(node, 0, 0, 1, "R9 restart mid-address");
    send_frame(node, 0, 20, 1, "R2 payload after address");
    idle(4);
    check(verdicts == checks / 2 - 1, "R2 one verdict per frame so far", verdicts, checks / 2 - 1);
    send_frame(node, 0, 0, 0, "R2 back-to-back first");
    send_frame('1, 0, 0, 0, "R2 back-to-back second");
    send_frame(node ^ 48'h1, 0, 0, 1, "R2 back-to-back third");
    idle(6);
    check(exp_q.size() == 0, "R2 all verdicts seen", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule